// File: doc/BRIEF.md
# NOR Flash Toggle-Bit Completion Poller

This block runs after software or a sequencer has sent a program or erase command to a parallel NOR flash. It watches the device's embedded operation by reading one status address over and over and looking at two data bits: a bit that flips on every read while the device is busy (bit 6), and a bit that the device sets when its internal operation has failed (bit 5). From these reads it decides whether the operation finished, failed or ran out of time.

A poll begins with a one-cycle `start` pulse, which carries the status address and a limit in clock ticks. The poller issues reads through a simple request/acknowledge port. Each read holds `rd_req` and `rd_addr` until the bus raises `rd_ack`, and `rd_data` is taken in that same cycle. The poll ends with a one-cycle `done` pulse and a two-bit `result`. A limit of zero gives up at once. A limit of all ones means there is no time limit.

Reads are always taken in pairs. If bit 6 has the same value in both reads of a pair, the device has stopped toggling. A failure is reported only after a second, confirming pair still toggles with bit 5 set. This avoids reporting a failure when the device completes at the same moment as bit 5 is seen.

Top module: `nor_toggle_poller`

## Requirements
- R1: After reset, `busy`, `done` and `rd_req` are low and `result` is 2'b00.
- R2: A `start` pulse while idle, with a nonzero limit, raises `busy` and begins reads. Every read drives `rd_addr` equal to the `start_addr` captured at start. `rd_req` stays high with a stable address until a cycle with `rd_ack` high, and `rd_data` is taken in that cycle.
- R3: If bit 6 is equal in the two reads of a pair, the poll ends with `result` = 2'b00 (success).
- R4: If bit 6 differs within a pair and bit 5 is clear in the first read of the pair, another pair of reads follows, unless the limit check (R6) ends the poll.
- R5: If bit 6 differs and bit 5 is set in the first read, one confirming pair follows. That pair ends the poll with 2'b01 (error) if it also toggles with bit 5 set in its first read. It ends with 2'b00 if bit 6 is equal. Otherwise polling continues as in R4.
- R6: The elapsed count is zero in the cycle after start and rises by one in every busy cycle, saturating at its maximum. Each read lasts at least one cycle, and each pair is followed by one evaluation cycle. At the evaluation of a pair that would continue polling under R4, the poll ends with 2'b10 (timeout) when the elapsed count is greater than the limit. A count equal to the limit does not end the poll.
- R7: A `start` with a limit of zero gives `done` with `result` = 2'b10 in the cycle after start, and issues no read.
- R8: A limit of all ones disables the timeout, so only R3 or R5 can end the poll.
- R9: `done` is high for exactly one cycle, with `busy` low. `result` changes only in the cycle in which `done` is high, and holds until the next `done`.
- R10: A `start` while `busy` is high is ignored: the address, the limit and the running poll are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a poll |
| start_addr | input | AW | Status address to poll, sampled at start |
| timeout_ticks | input | TW | Tick limit, sampled at start; 0 = give up at once, all ones = no limit |
| busy | output | 1 | Poll in progress |
| done | output | 1 | One-cycle end-of-poll pulse |
| result | output | 2 | 00 success, 01 device error, 10 timeout |
| rd_req | output | 1 | Read request, held until acknowledged |
| rd_addr | output | AW | Read address |
| rd_ack | input | 1 | Read acknowledge, data valid in this cycle |
| rd_data | input | DW | Read data from the flash |

## Verification
The assertions assume that `rd_ack` is raised only in cycles where `rd_req` is high. They also assume that `start` is a single-cycle pulse with `timeout_ticks` already valid in that cycle. The bench's bus model follows the first rule: it decides on an acknowledge at the falling edge, and only while a request is visible. The stimulus tasks drive the address and limit in the same falling-edge step that raises `start`, and drop `start` one cycle later. The model can also stall each acknowledge by a set number of cycles, which exercises the request-hold property without breaking those assumptions.

// File: rtl/nor_poll_pkg.sv
package nor_poll_pkg;

  typedef enum logic [1:0] {
    RES_OK   = 2'b00,
    RES_FAIL = 2'b01,
    RES_TMO  = 2'b10
  } poll_res_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD_A,
    ST_RD_B,
    ST_EVAL
  } poll_st_e;

  typedef enum logic [1:0] {
    V_OK,
    V_FAIL,
    V_AGAIN,
    V_CONFIRM
  } verdict_e;

endpackage

// File: rtl/nor_poll_timer.sv
// Elapsed-tick counter with limit compare; all-ones limit means unlimited.
module nor_poll_timer #(
  parameter int TW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          run,
  input  logic [TW-1:0] limit_in,
  output logic          expired,
  output logic          zero_lim
);
  localparam logic [TW-1:0] NO_LIMIT = {TW{1'b1}};
  localparam logic [TW-1:0] CNT_MAX  = {TW{1'b1}};

  logic [TW-1:0] lim_q, lim_d;
  logic [TW-1:0] el_q, el_d;
  logic          el_en, lim_en;

  always_comb begin
    lim_en = load;
    lim_d  = limit_in;
    el_en  = load | (run & (el_q != CNT_MAX));
    el_d   = load ? '0 : el_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q <= '0;
      el_q  <= '0;
    end else begin
      if (lim_en) lim_q <= lim_d;
      if (el_en)  el_q  <= el_d;
    end
  end

  assign expired  = (lim_q != NO_LIMIT) && (el_q > lim_q);
  assign zero_lim = (limit_in == '0);

endmodule

// File: rtl/nor_poll_rdport.sv
// Read port: holds the address, raises the request, captures both reads of a pair.
module nor_poll_rdport #(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] addr_in,
  input  logic          want,
  input  logic          slot,
  input  logic          rd_ack,
  input  logic [DW-1:0] rd_data,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  output logic          got,
  output logic [DW-1:0] first_q,
  output logic [DW-1:0] second_q
);
  localparam int NSLOT = 2;

  logic [AW-1:0] addr_q;
  logic [DW-1:0] cap_q [NSLOT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     addr_q <= '0;
    else if (load)  addr_q <= addr_in;
  end

  assign rd_req  = want;
  assign rd_addr = addr_q;
  assign got     = want & rd_ack;

  for (genvar g = 0; g < NSLOT; g++) begin : g_cap
    logic cen;
    assign cen = got & (slot == (g == 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cap_q[g] <= '0;
      else if (cen) cap_q[g] <= rd_data;
    end
  end

  assign first_q  = cap_q[0];
  assign second_q = cap_q[1];

endmodule

// File: rtl/nor_poll_judge.sv
// Pure decision logic for one completed pair of status reads.
module nor_poll_judge
  import nor_poll_pkg::*;
#(
  parameter int DW      = 16,
  parameter int TOG_BIT = 6,
  parameter int ERR_BIT = 5
) (
  input  logic [DW-1:0] first_w,
  input  logic [DW-1:0] second_w,
  input  logic          confirm,
  output verdict_e      verdict
);
  logic toggled, flagged;

  always_comb begin
    toggled = first_w[TOG_BIT] ^ second_w[TOG_BIT];
    flagged = first_w[ERR_BIT];
    if (!toggled)     verdict = V_OK;
    else if (!flagged) verdict = V_AGAIN;
    else if (confirm)  verdict = V_FAIL;
    else               verdict = V_CONFIRM;
  end

endmodule

// File: rtl/nor_poll_ctrl.sv
// Sequencer: pair reads, evaluation, limit check, result and done pulse.
module nor_poll_ctrl
  import nor_poll_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      zero_lim,
  input  logic      got,
  input  verdict_e  verdict,
  input  logic      expired,
  output logic      load,
  output logic      want,
  output logic      slot,
  output logic      confirm,
  output logic      busy,
  output logic      done,
  output logic [1:0] result
);
  poll_st_e  st_q, st_d;
  logic      conf_q, conf_d;
  logic      done_q, done_d;
  poll_res_e res_q, res_d;

  always_comb begin
    st_d   = st_q;
    conf_d = conf_q;
    done_d = 1'b0;
    res_d  = res_q;
    load   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          load = 1'b1;
          if (zero_lim) begin
            done_d = 1'b1;
            res_d  = RES_TMO;
          end else begin
            conf_d = 1'b0;
            st_d   = ST_RD_A;
          end
        end
      end
      ST_RD_A: if (got) st_d = ST_RD_B;
      ST_RD_B: if (got) st_d = ST_EVAL;
      ST_EVAL: begin
        unique case (verdict)
          V_OK: begin
            done_d = 1'b1; res_d = RES_OK; st_d = ST_IDLE;
          end
          V_FAIL: begin
            done_d = 1'b1; res_d = RES_FAIL; st_d = ST_IDLE;
          end
          V_CONFIRM: begin
            conf_d = 1'b1; st_d = ST_RD_A;
          end
          default: begin
            if (expired) begin
              done_d = 1'b1; res_d = RES_TMO; st_d = ST_IDLE;
            end else begin
              conf_d = 1'b0; st_d = ST_RD_A;
            end
          end
        endcase
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      conf_q <= 1'b0;
      done_q <= 1'b0;
      res_q  <= RES_OK;
    end else begin
      st_q   <= st_d;
      conf_q <= conf_d;
      done_q <= done_d;
      if (done_d) res_q <= res_d;
    end
  end

  assign want    = (st_q == ST_RD_A) || (st_q == ST_RD_B);
  assign slot    = (st_q == ST_RD_B);
  assign confirm = conf_q;
  assign busy    = (st_q != ST_IDLE);
  assign done    = done_q;
  assign result  = res_q;

endmodule

// File: rtl/nor_toggle_poller.sv
module nor_toggle_poller
  import nor_poll_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16,
  parameter int TW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [TW-1:0] timeout_ticks,
  output logic          busy,
  output logic          done,
  output logic [1:0]    result,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ack,
  input  logic [DW-1:0] rd_data
);
  localparam int TOG_BIT = 6;
  localparam int ERR_BIT = 5;

  logic          load, want, slot, confirm, got, expired, zero_lim;
  logic [DW-1:0] first_w, second_w;
  verdict_e      verdict;

  nor_poll_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .run(busy),
    .limit_in(timeout_ticks), .expired(expired), .zero_lim(zero_lim)
  );

  nor_poll_rdport #(.AW(AW), .DW(DW)) u_port (
    .clk(clk), .rst_n(rst_n), .load(load), .addr_in(start_addr),
    .want(want), .slot(slot), .rd_ack(rd_ack), .rd_data(rd_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .got(got),
    .first_q(first_w), .second_q(second_w)
  );

  nor_poll_judge #(.DW(DW), .TOG_BIT(TOG_BIT), .ERR_BIT(ERR_BIT)) u_judge (
    .first_w(first_w), .second_w(second_w), .confirm(confirm), .verdict(verdict)
  );

  nor_poll_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .zero_lim(zero_lim),
    .got(got), .verdict(verdict), .expired(expired),
    .load(load), .want(want), .slot(slot), .confirm(confirm),
    .busy(busy), .done(done), .result(result)
  );

endmodule

// File: rtl/nor_toggle_poller_chk.sv
module nor_toggle_poller_chk #(
  parameter int AW = 24,
  parameter int TW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [TW-1:0] timeout_ticks,
  input logic          busy,
  input logic          done,
  input logic [1:0]    result,
  input logic          rd_req,
  input logic          rd_ack,
  input logic [AW-1:0] rd_addr
);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req);

  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

  p_zero_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && timeout_ticks == '0) |=> (done && result == 2'b10));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

  p_addr_fixed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(rd_addr)));

endmodule

bind nor_toggle_poller nor_toggle_poller_chk #(.AW(AW), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .timeout_ticks(timeout_ticks),
  .busy(busy), .done(done), .result(result), .rd_req(rd_req),
  .rd_ack(rd_ack), .rd_addr(rd_addr)
);

// File: tb/nor_toggle_poller_bench.sv
module nor_toggle_poller_bench;
  localparam int AW = 24;
  localparam int DW = 16;
  localparam int TW = 24;
  localparam logic [TW-1:0] UNLIM = {TW{1'b1}};
  localparam int NEVER = 1 << 30;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [TW-1:0] timeout_ticks = '0;
  logic          busy, done, rd_req, rd_ack = 1'b0;
  logic [1:0]    result;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data = '0;

  int total = 0, bad = 0, cyc = 0;
  int n_tog = 0, f5_at = NEVER, stall_cfg = 0, stall_cnt = 0;
  int idx = 0, addr_bad = 0;
  logic [AW-1:0] exp_addr = '0;
  logic [1:0] got_res;
  int got_reads;

  always #4 clk = ~clk;

  nor_toggle_poller #(.AW(AW), .DW(DW), .TW(TW)) u_nor_toggle_poller (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .timeout_ticks(timeout_ticks), .busy(busy), .done(done), .result(result),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data)
  );

  function automatic logic [DW-1:0] word(input int i);
    logic [DW-1:0] w;
    w = 16'h0A0F;
    w[6] = (i < n_tog) ? i[0] : 1'b0;
    w[5] = (i >= f5_at);
    return w;
  endfunction

  // bus model: decides acknowledge at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (rd_req && stall_cnt >= stall_cfg) begin
      rd_ack = 1'b1;
      rd_data = word(idx);
      if (rd_addr != exp_addr) addr_bad++;
      idx++;
      stall_cnt = 0;
    end else begin
      rd_ack = 1'b0;
      if (rd_req) stall_cnt++;
    end
    if (cyc > 150000) begin
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic launch(input logic [AW-1:0] a, input logic [TW-1:0] t,
                        input int n, input int f5, input int st);
    @(negedge clk);
    n_tog = n; f5_at = f5; stall_cfg = st; stall_cnt = 0; idx = 0; addr_bad = 0;
    exp_addr = a;
    start = 1'b1; start_addr = a; timeout_ticks = t;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int waited);
    waited = 0;
    while (!done && waited < 3000) begin
      @(negedge clk);
      waited++;
    end
    if (!done) chk(1'b0, "watchdog", 0, 1);
    got_res = result;
    got_reads = idx;
  endtask

  task automatic run_one(input logic [AW-1:0] a, input logic [TW-1:0] t,
                         input int n, input int f5, input int st);
    int w;
    launch(a, t, n, f5, st);
    wait_done(w);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk(!busy && !done && !rd_req, "R1 idle outputs", {busy, done, rd_req}, 0);
    chk(result == 2'b00, "R1 result", result, 0);
  endtask

  task automatic t_quick_ok;
    run_one(24'h000AAA, 24'd1000, 0, NEVER, 0);
    chk(got_res == 2'b00, "R3 stable pair result", got_res, 0);
    chk(got_reads == 2, "R3 stable pair reads", got_reads, 2);
    chk(addr_bad == 0, "R2 read address", addr_bad, 0);
  endtask

  task automatic t_toggle_ok;
    run_one(24'h123456, 24'd1000, 6, NEVER, 0);
    chk(got_res == 2'b00, "R4 toggle then stable result", got_res, 0);
    chk(got_reads == 8, "R4 toggle then stable reads", got_reads, 8);
    chk(!done && !busy, "R9 done single pulse", done, 0);
  endtask

  task automatic t_fail;
    run_one(24'h000100, 24'd1000, 100, 4, 0);
    chk(got_res == 2'b01, "R5 confirmed error result", got_res, 1);
    chk(got_reads == 8, "R5 confirmed error reads", got_reads, 8);
  endtask

  task automatic t_flag_then_ok;
    run_one(24'h000200, 24'd1000, 6, 4, 0);
    chk(got_res == 2'b00, "R5 flag then completion", got_res, 0);
    chk(got_reads == 8, "R5 flag then completion reads", got_reads, 8);
  endtask

  task automatic t_timeout;
    run_one(24'h000300, 24'd10, 1000, NEVER, 0);
    chk(got_res == 2'b10, "R6 limit 10 result", got_res, 2);
    chk(got_reads == 8, "R6 limit 10 reads", got_reads, 8);
    run_one(24'h000300, 24'd11, 1000, NEVER, 0);
    chk(got_res == 2'b10, "R6 limit 11 result", got_res, 2);
    chk(got_reads == 10, "R6 equal count not expired", got_reads, 10);
  endtask

  task automatic t_zero;
    int w;
    launch(24'h000400, 24'd0, 1000, NEVER, 0);
    chk(done == 1'b1, "R7 done cycle after start", done, 1);
    wait_done(w);
    chk(got_res == 2'b10, "R7 zero limit result", got_res, 2);
    chk(got_reads == 0, "R7 zero limit reads", got_reads, 0);
    @(negedge clk);
  endtask

  task automatic t_unlimited;
    run_one(24'h000500, UNLIM, 60, NEVER, 0);
    chk(got_res == 2'b00, "R8 unlimited result", got_res, 0);
    chk(got_reads == 62, "R8 unlimited reads", got_reads, 62);
  endtask

  task automatic t_stall;
    run_one(24'h000600, 24'd1000, 4, NEVER, 2);
    chk(got_res == 2'b00, "R2 stalled bus result", got_res, 0);
    chk(got_reads == 6, "R2 stalled bus reads", got_reads, 6);
    chk(addr_bad == 0, "R2 stalled address", addr_bad, 0);
  endtask

  task automatic t_hold;
    logic [1:0] r;
    run_one(24'h000700, 24'd1000, 100, 2, 0);
    r = result;
    repeat (5) @(negedge clk);
    chk(result == r && r == 2'b01, "R9 result held", result, r);
    chk(!done, "R9 done low after pulse", done, 0);
  endtask

  task automatic t_busy_start;
    int w;
    launch(24'h000800, UNLIM, 60, NEVER, 0);
    repeat (10) @(negedge clk);
    start = 1'b1; start_addr = 24'h0FFFFF; timeout_ticks = 24'd0;
    @(negedge clk);
    start = 1'b0;
    wait_done(w);
    chk(got_res == 2'b00, "R10 start while busy result", got_res, 0);
    chk(got_reads == 62, "R10 start while busy reads", got_reads, 62);
    chk(addr_bad == 0, "R10 address unchanged", addr_bad, 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_quick_ok();
    t_toggle_ok();
    t_fail();
    t_flag_then_ok();
    t_timeout();
    t_zero();
    t_unlimited();
    t_stall();
    t_hold();
    t_busy_start();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule